// File: doc/BRIEF.md
# Pipelined Memory Address Generator

This block forms data-memory addresses one micro-cycle before the memory transfer that uses them, and holds each result in a memory address register (MAR). Each micro-instruction carries an address field that is separate from its execution field. The address field holds three values:

- a 12-bit displacement,
- a base register number,
- an index register number.

Register contents arrive over one register-file read port. The block drives the read address of that port itself.

The block has only a two-input adder. An address with no index takes one cycle: the base value plus the zero-extended displacement goes into the MAR. An address with an index takes two cycles: first the same base-plus-displacement step, then the index value is added to the MAR. A caller that reuses the same base and index pair can hold their sum in a spare register and pass it as the base, which brings the address back to one cycle.

The MAR is decoded into three outputs:

- a one-hot select for up to 14 memory boards of 256 KiB each,
- an address-error flag for addresses beyond the last board,
- a byte-lane offset within the 64-bit bus word.

Loading an address that is never used, for example one computed ahead of a taken branch, only overwrites the MAR.

Top module: `mar_addr_gen`

## Requirements
- R1: After reset the MAR is 0, and `addrReady` and `busy` are 0.
- R2: When `calcValid` is high with `idxSel` = 0 and the block is not busy, after the next clock edge the MAR holds the base register value plus the zero-extended displacement. For that one cycle `addrReady` is 1 and `busy` is 0.
- R3: Register number 0 in the base or index position contributes zero, whatever the register file returns for address 0.
- R4: When `calcValid` is high with `idxSel` ≠ 0, the first edge loads the MAR with base plus displacement, with `busy` = 1 and `addrReady` = 0. The second edge adds the index register value to the MAR, with `addrReady` = 1 and `busy` = 0.
- R5: A request presented while `busy` is 1 is ignored and does not change the result.
- R6: Addition wraps modulo 2^24.
- R7: Requests without an index, presented on consecutive cycles, produce one new address per cycle.
- R8: With board number b = MAR[23:18] and b < 14, `boardSel` has only bit b set and `addrErr` is 0.
- R9: With b ≥ 14, `addrErr` is 1 and `boardSel` is all zero.
- R10: `laneOff` equals MAR[2:0].
- R11: In a cycle with no accepted request and no index step, the MAR keeps its value.
- R12: `regRdAddr` equals `baseSel` in the cycle a request is accepted, and equals the latched index number during the index step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calcValid | input | 1 | An address field is present this cycle |
| dispIn | input | 12 | Displacement |
| baseSel | input | 4 | Base register number (0 means none) |
| idxSel | input | 4 | Index register number (0 means none) |
| regRdAddr | output | 4 | Register-file read address |
| regRdData | input | 24 | Register-file read data (same cycle) |
| mar | output | 24 | Memory address register |
| laneOff | output | 3 | Byte offset within the 64-bit word |
| boardSel | output | 14 | One-hot memory board select |
| addrErr | output | 1 | Address is beyond the last board |
| addrReady | output | 1 | MAR holds a completed address |
| busy | output | 1 | Index step in progress |

## Verification
Results fall due at two different distances from the request:

- An address without an index is due one clock edge after the request.
- An address with an index shows its partial sum one edge after the request and its final sum two edges after.
- The read address is combinational, so it is checked in the same cycle the request is driven.

The driver pushes one expected MAR/ready/busy item for each cycle it drives. The monitor pops one item shortly after every rising edge, so each comparison lands in the cycle the result is due. Board select, error flag and lane are derived from the expected MAR, using the field positions given in the requirements.

// File: rtl/mag_pkg.sv
package mag_pkg;
  localparam int ADDR_W_DEF    = 24;
  localparam int DISP_W_DEF    = 12;
  localparam int REG_AW_DEF    = 4;
  localparam int BOARD_OFF_DEF = 18;
  localparam int NUM_BOARD_DEF = 14;
  localparam int LANE_W_DEF    = 3;

  typedef struct packed {
    logic loadBase;   // MAR <= disp + base
    logic addIdx;     // MAR <= MAR + index
    logic finish;     // address complete after this edge
    logic zeroOp;     // selected register is number 0
  } magStrobe_t;
endpackage

// File: rtl/mag_ctrl.sv
module mag_ctrl
  import mag_pkg::*;
#(
  parameter int REG_AW = REG_AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              calcValid,
  input  logic [REG_AW-1:0] baseSel,
  input  logic [REG_AW-1:0] idxSel,
  output logic [REG_AW-1:0] rdSel,
  output magStrobe_t        strb,
  output logic              busyQ
);
  logic [REG_AW-1:0] idxQ;
  logic              needIdx;

  assign needIdx = (idxSel != '0);

  always_comb begin
    strb   = '0;
    rdSel  = busyQ ? idxQ : baseSel;
    if (busyQ) begin
      strb.addIdx = 1'b1;
      strb.finish = 1'b1;
    end else if (calcValid) begin
      strb.loadBase = 1'b1;
      strb.finish   = !needIdx;
    end
    strb.zeroOp = (rdSel == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (!busyQ && calcValid && needIdx) begin
      busyQ <= 1'b1;
      idxQ  <= idxSel;
    end else begin
      busyQ <= 1'b0;
    end
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |=> !busyQ); // R4
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> $past(calcValid && (idxSel != '0))); // R5
endmodule

// File: rtl/mag_dpath.sv
module mag_dpath
  import mag_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int DISP_W    = DISP_W_DEF,
  parameter int BOARD_OFF = BOARD_OFF_DEF,
  parameter int NUM_BOARD = NUM_BOARD_DEF,
  parameter int LANE_W    = LANE_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  magStrobe_t           strb,
  input  logic [DISP_W-1:0]    dispIn,
  input  logic [ADDR_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]    mar,
  output logic [LANE_W-1:0]    laneOff,
  output logic [NUM_BOARD-1:0] boardSel,
  output logic                 addrErr,
  output logic                 addrReady
);
  localparam int BRD_W = ADDR_W - BOARD_OFF;

  logic [ADDR_W-1:0] dispExt, opA, opB, sum;
  logic [BRD_W-1:0]  boardIdx;

  assign dispExt = {{(ADDR_W-DISP_W){1'b0}}, dispIn};
  assign opA     = strb.loadBase ? dispExt : mar;
  assign opB     = strb.zeroOp ? '0 : regRdData;
  assign sum     = opA + opB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar       <= '0;
      addrReady <= 1'b0;
    end else begin
      if (strb.loadBase || strb.addIdx) mar <= sum;
      addrReady <= strb.finish;
    end
  end

  assign laneOff  = mar[LANE_W-1:0];
  assign boardIdx = mar[ADDR_W-1:BOARD_OFF];
  assign addrErr  = (boardIdx >= BRD_W'(NUM_BOARD));

  for (genvar g = 0; g < NUM_BOARD; g++) begin : gBoard
    assign boardSel[g] = (boardIdx == BRD_W'(g));
  end

  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.loadBase || strb.addIdx) |=> $stable(mar)); // R11
  AST_BOARD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boardSel)); // R8
  AST_ERR_NO_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
    addrErr |-> (boardSel == '0)); // R9
endmodule

// File: rtl/mar_addr_gen.sv
module mar_addr_gen
  import mag_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int DISP_W    = DISP_W_DEF,
  parameter int REG_AW    = REG_AW_DEF,
  parameter int BOARD_OFF = BOARD_OFF_DEF,
  parameter int NUM_BOARD = NUM_BOARD_DEF,
  parameter int LANE_W    = LANE_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calcValid,
  input  logic [DISP_W-1:0]    dispIn,
  input  logic [REG_AW-1:0]    baseSel,
  input  logic [REG_AW-1:0]    idxSel,
  output logic [REG_AW-1:0]    regRdAddr,
  input  logic [ADDR_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]    mar,
  output logic [LANE_W-1:0]    laneOff,
  output logic [NUM_BOARD-1:0] boardSel,
  output logic                 addrErr,
  output logic                 addrReady,
  output logic                 busy
);
  magStrobe_t strb;

  mag_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .calcValid(calcValid),
    .baseSel(baseSel), .idxSel(idxSel),
    .rdSel(regRdAddr), .strb(strb), .busyQ(busy)
  );

  mag_dpath #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .BOARD_OFF(BOARD_OFF),
    .NUM_BOARD(NUM_BOARD), .LANE_W(LANE_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dispIn(dispIn),
    .regRdData(regRdData), .mar(mar), .laneOff(laneOff),
    .boardSel(boardSel), .addrErr(addrErr), .addrReady(addrReady)
  );

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addrReady |-> !busy); // R2
endmodule

// File: tb/sim_mar_addr_gen.sv
module sim_mar_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        calcValid = 1'b0;
  logic [11:0] dispIn = '0;
  logic [3:0]  baseSel = '0, idxSel = '0, regRdAddr;
  logic [23:0] regRdData, mar;
  logic [2:0]  laneOff;
  logic [13:0] boardSel;
  logic        addrErr, addrReady, busy;

  logic [23:0] regs [16];
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [23:0] eMar;
    logic        eRdy;
    logic        eBusy;
    int          req;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  assign regRdData = regs[regRdAddr];

  mar_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .calcValid(calcValid), .dispIn(dispIn),
    .baseSel(baseSel), .idxSel(idxSel), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .mar(mar), .laneOff(laneOff),
    .boardSel(boardSel), .addrErr(addrErr), .addrReady(addrReady), .busy(busy)
  );

  function automatic logic [23:0] regVal(input logic [3:0] r);
    return (r == 4'd0) ? 24'd0 : regs[r];
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue what must appear after the edge
  task automatic step(input logic v, input logic [11:0] d, input logic [3:0] b,
                      input logic [3:0] i, input logic [23:0] eMar,
                      input logic eRdy, input logic eBusy, input int req,
                      input logic [3:0] eRd);
    expItem_t it;
    @(negedge clk);
    calcValid = v; dispIn = d; baseSel = b; idxSel = i;
    #1;
    chk(regRdAddr == eRd, 12, "regRdAddr", 24'(regRdAddr), 24'(eRd)); // R12
    it.eMar = eMar; it.eRdy = eRdy; it.eBusy = eBusy; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        logic [5:0]  bIdx;
        logic [13:0] eSel;
        it = expQ.pop_front();
        bIdx = it.eMar[23:18];
        eSel = (bIdx < 6'd14) ? (14'(1) << bIdx) : 14'd0;
        chk(mar == it.eMar, it.req, "mar", mar, it.eMar);
        chk(addrReady == it.eRdy, it.req, "addrReady", 24'(addrReady), 24'(it.eRdy));
        chk(busy == it.eBusy, it.req, "busy", 24'(busy), 24'(it.eBusy));
        chk(boardSel == eSel, 8, "boardSel", 24'(boardSel), 24'(eSel));           // R8
        chk(addrErr == (bIdx >= 6'd14), 9, "addrErr", 24'(addrErr),
            24'(bIdx >= 6'd14));                                                  // R9
        chk(laneOff == it.eMar[2:0], 10, "laneOff", 24'(laneOff), 24'(it.eMar[2:0])); // R10
      end
    end
  end

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    logic [23:0] m;
    for (int k = 1; k < 12; k++) regs[k] = 24'(k) * 24'h040000 + 24'(k) * 24'h111;
    regs[0]  = 24'hABCDEF;  // must never contribute
    regs[12] = 24'h37F000;
    regs[13] = 24'h340008;
    regs[14] = 24'h380000;
    regs[15] = 24'hFFFF00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mar == 24'd0, 1, "mar reset", mar, 24'd0);                            // R1
    chk(addrReady == 1'b0, 1, "ready reset", 24'(addrReady), 24'd0);          // R1
    chk(busy == 1'b0, 1, "busy reset", 24'(busy), 24'd0);                     // R1
    rst_n = 1'b1;

    // R2 single step
    m = regVal(3) + 24'h123;
    step(1, 12'h123, 3, 0, m, 1, 0, 2, 3);
    // R11 hold with no request
    step(0, 12'h0, 5, 0, m, 0, 0, 11, 5);
    step(0, 12'h0, 7, 0, m, 0, 0, 11, 7);
    // R3 base register 0 contributes zero
    step(1, 12'h7FF, 0, 0, 24'h0007FF, 1, 0, 3, 0);
    // R7 back-to-back one per cycle
    step(1, 12'h008, 5, 0, regVal(5) + 24'h8, 1, 0, 7, 5);
    step(1, 12'h010, 6, 0, regVal(6) + 24'h10, 1, 0, 7, 6);
    step(1, 12'h040, 13, 0, regVal(13) + 24'h40, 1, 0, 7, 13);
    // R4 two-step with index; R5 request during busy ignored
    m = regVal(2) + 24'h20;
    step(1, 12'h020, 2, 7, m, 0, 1, 4, 2);
    step(1, 12'hFFF, 9, 0, m + regVal(7), 1, 0, 5, 7);
    step(0, 12'h0, 0, 0, m + regVal(7), 0, 0, 11, 0);
    // R6 wrap modulo 2^24
    step(1, 12'h1FF, 15, 0, 24'h0000FF, 1, 0, 6, 15);
    // R9 first missing board, R8 last board edge
    step(1, 12'h000, 14, 0, 24'h380000, 1, 0, 9, 14);
    step(1, 12'hFFF, 12, 0, 24'h37FFFF, 1, 0, 8, 12);
    // R3 base 0 with index, R4 index step
    step(1, 12'h010, 0, 4, 24'h000010, 0, 1, 3, 0);
    step(0, 12'h0, 0, 0, 24'h000010 + regVal(4), 1, 0, 4, 4);
    // index on top of wrap
    m = regVal(15) + 24'h100;
    step(1, 12'h100, 15, 11, m, 0, 1, 6, 15);
    step(0, 12'h0, 1, 0, m + regVal(11), 1, 0, 6, 11);
    step(0, 12'h0, 1, 0, m + regVal(11), 0, 0, 11, 1);

    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule